// File: doc/BRIEF.md
# Byte Convolutional Interleaver with Zero-Fill Start

This block spreads a byte stream over a set of delay lines of growing length, so that a burst of errors in the channel lands on bytes that are far apart after de-interleaving. A commutator steps through the branches on every accepted byte. Branch 0 passes its byte straight through. Branch j returns the byte written to it j·UNIT visits earlier. All delay lines share one memory, and each branch keeps its own rotating read/write pointer.

After reset the block writes zero into every memory word, one word per clock, and raises `busy` while it does so. When `zero_start` is high, the output stays a well-defined run of zero bytes until the first packet sync-start pulse. From that byte onward the block interleaves normally, and the delay lines start out holding only zeros. When `zero_start` is low, interleaving begins as soon as the clear ends. A sync-start pulse always puts its byte on branch 0, which aligns the commutator with the packet structure. The block has no backpressure.

Top module: `conv_interleaver`

## Requirements
- R1: While reset is held, `out_valid` is 0 and `busy` is 1. After reset is released, `busy` stays high for exactly DEPTH = UNIT·B·(B−1)/2 clock cycles (one memory word cleared per cycle). It then falls and does not rise again until the next reset.
- R2: While `busy` is high, input bytes are ignored: `out_valid` stays 0 and no branch or memory state changes.
- R3: A byte accepted in a cycle (`in_valid` high, `busy` low) gives `out_valid` high with its result in the next cycle. A cycle without an accepted byte gives `out_valid` low in the next cycle.
- R4: Each byte that is interleaved moves the commutator to the next branch, and the commutator wraps from branch B−1 to branch 0.
- R5: A byte on branch 0 is output unchanged. A byte on branch j ≥ 1 outputs the byte written to branch j on the j·UNIT-th earlier visit to that branch, or zero if there were not that many visits since the clear.
- R6: A byte with `in_sync` high is always placed on branch 0, whatever the commutator position.
- R7: With `zero_start` = 1, every accepted byte after the clear and before the first sync-start byte produces a valid output of zero. Such bytes leave the commutator and the memory untouched.
- R8: The first accepted sync-start byte ends the zero-fill hold. That byte and all later bytes are interleaved normally, starting from all-zero delay lines.
- R9: With `zero_start` = 0, interleaving begins with the first byte accepted after the clear, on branch 0, without waiting for a sync-start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zero_start | input | 1 | 1: output zeros until first sync-start byte; 0: interleave at once |
| in_valid | input | 1 | Input byte valid |
| in_sync | input | 1 | Input byte is the first byte of a packet |
| in_data | input | W | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | W | Interleaved output byte |
| busy | output | 1 | Memory clear in progress |

## Verification
The bench builds the interleaver with W = 8, B = 4 and UNIT = 3, which gives a shared memory of 18 words. With this size the full clear, several commutator wraps and the full delay of the longest branch all fit into a few hundred cycles. A byte-level model with one shift queue per branch, written from the requirements, predicts each output byte. The stimulus covers the zero-fill hold, the sync that ends it, a mid-stream resync, gaps in `in_valid`, and the direct start with `zero_start` low.

// File: rtl/conv_interleaver.sv
module conv_interleaver #(
  parameter int W    = 8,
  parameter int B    = 12,
  parameter int UNIT = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_start,
  input  logic         in_valid,
  input  logic         in_sync,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy
);
  localparam int DEPTH = UNIT * B * (B - 1) / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(UNIT * (B - 1) + 1);
  localparam int BW    = $clog2(B);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] clr_addr;
  logic          busy_q;
  logic          waiting;
  logic [BW-1:0] branch;
  logic [PW-1:0] ptr [B];

  function automatic logic [AW-1:0] base_of(input logic [BW-1:0] b);
    int v;
    v = UNIT * int'(b) * (int'(b) - 1) / 2;
    return AW'(v);
  endfunction

  wire           take   = in_valid && !busy_q;
  wire           hold   = zero_start && waiting && !in_sync;
  wire [BW-1:0]  sel    = in_sync ? '0 : branch;
  wire [AW-1:0]  addr   = base_of(sel) + AW'(ptr[sel]);
  wire           stores = take && !hold && (sel != '0);

  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (busy_q)
      mem[clr_addr] <= '0;
    else if (stores)
      mem[addr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b1;
      clr_addr  <= '0;
      waiting   <= 1'b1;
      branch    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < B; i++) ptr[i] <= '0;
    end else begin
      if (busy_q) begin
        if (clr_addr == AW'(DEPTH - 1))
          busy_q <= 1'b0;
        else
          clr_addr <= clr_addr + 1'b1;
      end
      out_valid <= take;
      if (take) begin
        if (hold) begin
          out_data <= '0;
        end else begin
          if (in_sync) waiting <= 1'b0;
          out_data <= (sel == '0) ? in_data : mem[addr];
          branch   <= (sel == BW'(B - 1)) ? '0 : sel + 1'b1;
          if (sel != '0)
            ptr[sel] <= (ptr[sel] == PW'(int'(sel) * UNIT - 1)) ? '0 : ptr[sel] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_interleaver_chk.sv
module conv_interleaver_chk #(
  parameter int W  = 8,
  parameter int B  = 12,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          zero_start,
  input logic          in_valid,
  input logic          in_sync,
  input logic          busy,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          waiting,
  input logic [BW-1:0] branch
);
  // R1
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !busy);
  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !out_valid);
  // R3
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !busy) |=> out_valid);
  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R4
  branch_range_chk: assert property (@(posedge clk) disable iff (!rst_n) branch <= BW'(B - 1));
  // R6
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && in_sync) |=> branch == BW'(1));
  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && zero_start && waiting && !in_sync) |=> (out_data == '0 && $stable(branch)));
  // R8
  hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && in_sync) |=> !waiting);
endmodule

bind conv_interleaver conv_interleaver_chk #(.W(W), .B(B), .BW(BW)) chk (
  .clk(clk), .rst_n(rst_n), .zero_start(zero_start), .in_valid(in_valid),
  .in_sync(in_sync), .busy(busy), .out_valid(out_valid), .out_data(out_data),
  .waiting(waiting), .branch(branch)
);

// File: tb/conv_interleaver_test.sv
module conv_interleaver_test;
  localparam int W = 8, B = 4, U = 3;
  localparam int DEPTH = U * B * (B - 1) / 2;
  localparam int MAXD = U * (B - 1);

  logic clk = 1'b0, rst_n = 1'b0, zero_start = 1'b1;
  logic in_valid = 1'b0, in_sync = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid, busy;
  logic [W-1:0] out_data;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [W-1:0] mq [B][MAXD];
  int mb;
  bit mwait;

  conv_interleaver #(.W(W), .B(B), .UNIT(U)) uut (
    .clk(clk), .rst_n(rst_n), .zero_start(zero_start), .in_valid(in_valid),
    .in_sync(in_sync), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int j = 0; j < B; j++)
      for (int k = 0; k < MAXD; k++) mq[j][k] = '0;
    mb = 0;
    mwait = 1;
  endtask

  task automatic model_step(input bit s, input logic [W-1:0] d, output logic [W-1:0] e);
    int j;
    if (zero_start && mwait && !s) begin
      e = '0;
      return;
    end
    if (s) begin
      mb = 0;
      mwait = 0;
    end
    j = mb;
    if (j == 0) e = d;
    else begin
      e = mq[j][j * U - 1];
      for (int k = MAXD - 1; k > 0; k--) mq[j][k] = mq[j][k - 1];
      mq[j][0] = d;
    end
    mb = (j + 1) % B;
  endtask

  task automatic push(input bit v, input bit s, input logic [W-1:0] d, input string tag);
    logic [W-1:0] e;
    e = '0;
    in_valid = v;
    in_sync = s;
    in_data = d;
    if (v) model_step(s, d, e);
    @(negedge clk);
    check(out_valid == v, "R3 out_valid", int'(out_valid), int'(v));
    if (v) check(out_data == e, tag, int'(out_data), int'(e));
  endtask

  task automatic do_reset(input bit zs);
    int n;
    zero_start = zs;
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(busy == 1'b1, "R1 reset busy", int'(busy), 1);
    rst_n = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hA5;
    in_sync = 1'b1;
    n = 0;
    while (busy && n < 10 * DEPTH) begin
      @(negedge clk);
      n++;
      if (busy) check(out_valid == 1'b0, "R2 ignored while busy", int'(out_valid), 0);
    end
    check(n == DEPTH, "R1 clear length", n, DEPTH);
    in_valid = 1'b0;
    in_sync = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 nothing accepted", int'(out_valid), 0);
    check(busy == 1'b0, "R1 busy stays low", int'(busy), 0);
    model_clear();
  endtask

  task automatic test_hold();
    do_reset(1'b1);
    for (int i = 0; i < 10; i++) push(1'b1, 1'b0, 8'(i * 13 + 5), "R7 zero hold");
  endtask

  task automatic test_sync_start();
    push(1'b1, 1'b1, 8'h3C, "R8 first sync byte");
    for (int i = 0; i < 60; i++) push(1'b1, 1'b0, 8'(i * 7 + 3), "R4/R5 interleave");
  endtask

  task automatic test_gaps();
    for (int i = 0; i < 30; i++) push(i % 3 != 0, 1'b0, 8'(i * 11 + 1), "R3 gapped");
  endtask

  task automatic test_resync();
    push(1'b1, 1'b1, 8'h77, "R6 resync");
    for (int i = 0; i < 5; i++) push(1'b1, 1'b0, 8'(i + 90), "R6 after resync");
    push(1'b1, 1'b1, 8'h55, "R6 resync mid-rotation");
    for (int i = 0; i < 40; i++) push(1'b1, 1'b0, 8'(i * 5 + 200), "R5 after resync");
  endtask

  task automatic test_direct();
    do_reset(1'b0);
    push(1'b1, 1'b0, 8'h9E, "R9 first byte passes branch 0");
    for (int i = 0; i < 50; i++) push(1'b1, 1'b0, 8'(i * 3 + 17), "R9 direct interleave");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_hold();
    test_sync_start();
    test_gaps();
    test_resync();
    test_direct();
    test_resync();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule